// File: doc/BRIEF.md
# Signed Sequential Word Divider

This block divides a signed two-word dividend (two 16-bit halves, 32 bits in all with the default width) by a signed one-word divisor. It produces a truncated quotient, a remainder and four condition flags. A processor's arithmetic unit uses it as the execution stage of a divide operation. The unit pulses `start` with the operands. The block then works for a fixed number of cycles and presents its results together with a one-cycle `done` pulse. The results stay on the outputs until the next operation completes.

The block works internally on magnitudes and applies the signs afterwards. Before the loop starts, a magnitude comparison catches quotients that cannot fit in a word. A final test at the signed boundary separates the legal most-negative quotient from real overflow. In single-register mode the dividend is built from one word repeated in both halves, and only the remainder is meaningful.

Top module: `sdiv_top`

## Requirements
- R1: When V is clear, the quotient is the true quotient truncated toward zero. The remainder satisfies quotient*divisor + remainder = dividend, has magnitude below the divisor's, and is zero or carries the dividend's sign (e.g. 34/-5 gives -6 rem 4; -34/5 gives -6 rem -4).
- R2: `done` is high for exactly one cycle. It rises after the (W/STEPS + 1)-th rising edge that follows the edge which accepted `start`, which is 17 edges with the defaults. Otherwise it is low.
- R3: A `start` that arrives while an operation is in progress is ignored. The running operation finishes on time with its original operands.
- R4: A zero divisor gives flags = {N,Z,V,C} = 4'b0111.
- R5: With no overflow, N equals the quotient's sign bit, Z is set exactly when the quotient is zero, and V and C are clear.
- R6: When the true quotient lies outside -32768..32767 (-2^(W-1)..2^(W-1)-1), V is set and C is clear (e.g. -32768/-1, 0x7fffffff/2).
- R7: A quotient of exactly -32768 is legal. For example, 715871573/-21846 gives -32768 rem 21845 with no overflow, while 715871574/-21846 overflows.
- R8: On overflow, N is the sign of the true quotient and Z is clear (0x7fffffff/-1 gives 4'b1010; 0x80000000/-1 gives 4'b0010).
- R9: With `odd_mode` high, the dividend is {dvd_lo, dvd_lo} and `dvd_hi` is ignored. The flags come from that quotient, `rem` carries the remainder and `quot` reads zero.
- R10: After reset, `done`, `quot`, `rem` and `flags` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation when idle |
| odd_mode | input | 1 | Single-register dividend form |
| dvd_hi | input | W | Upper dividend word |
| dvd_lo | input | W | Lower dividend word |
| dvs | input | W | Signed divisor |
| quot | output | W | Signed quotient |
| rem | output | W | Signed remainder |
| flags | output | 4 | {N, Z, V, C} |
| done | output | 1 | One-cycle result strobe |

## Verification
On every cycle, the assertions check these properties:
- the `done` pulse width;
- the divide-by-zero flag pattern;
- the flag consistency of a valid quotient;
- the remainder sign;
- the absence of C on overflow;
- that the latched divisor stays unchanged under a start while busy;
- that the quotient reads zero in single-register mode.

Only the bench's scenarios can show that the values themselves are right. These include the four sign quadrants and the exact edges of the signed quotient range, where -32768 must pass and one more must overflow. They also include the sign reported on overflow and the exact cycle on which results appear. The bench compares every cycle against a behavioural model that uses integer division.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_FIN  = 2'd2
   } sdiv_state_e;

   typedef struct packed {
      logic n;
      logic z;
      logic v;
      logic c;
   } sdiv_flags_t;
endpackage

// File: rtl/sdiv_prep.sv
module sdiv_prep #(
   parameter int W = 16
) (
   input  logic [2*W-1:0] dd,
   input  logic [W-1:0]   dr,
   output logic [2*W-1:0] dd_mag,
   output logic [W-1:0]   dr_mag,
   output logic           dd_neg,
   output logic           q_neg,
   output logic           dr_zero,
   output logic           early_ovf
);
   localparam int DW = 2 * W;

   always_comb begin
      dd_neg    = dd[DW-1];
      q_neg     = dd[DW-1] ^ dr[W-1];
      dd_mag    = dd_neg ? (DW'(0) - dd) : dd;
      dr_mag    = dr[W-1] ? (W'(0) - dr) : dr;
      dr_zero   = (dr == '0);
      // |dd| >= |dr| * 2^W means the magnitude quotient needs more than W bits
      early_ovf = (dd_mag[DW-1:W] >= dr_mag);
   end
endmodule

// File: rtl/sdiv_step.sv
module sdiv_step #(
   parameter int W = 16
) (
   input  logic [W-1:0] rem_i,
   input  logic [W-1:0] quo_i,
   input  logic [W-1:0] dr_mag,
   output logic [W-1:0] rem_o,
   output logic [W-1:0] quo_o
);
   logic [W:0] trial;
   logic       fits;

   always_comb begin
      trial = {rem_i, quo_i[W-1]};
      fits  = (trial >= {1'b0, dr_mag});
      rem_o = fits ? W'(trial - {1'b0, dr_mag}) : trial[W-1:0];
      quo_o = {quo_i[W-2:0], fits};
   end
endmodule

// File: rtl/sdiv_top.sv
module sdiv_top #(
   parameter int W     = 16,
   parameter int STEPS = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic         odd_mode,
   input  logic [W-1:0] dvd_hi,
   input  logic [W-1:0] dvd_lo,
   input  logic [W-1:0] dvs,
   output logic [W-1:0] quot,
   output logic [W-1:0] rem,
   output logic [3:0]   flags,
   output logic         done
);
   import sdiv_pkg::*;

   localparam int DW    = 2 * W;
   localparam int NITER = W / STEPS;
   localparam int CW    = $clog2(NITER + 1);
   localparam logic [W-1:0] Q_NEG_LIM = {1'b1, {(W-1){1'b0}}};
   localparam logic [W-1:0] Q_POS_LIM = {1'b0, {(W-1){1'b1}}};

   if (W < 4 || (W % 2) != 0) begin : g_bad_width
      $error("sdiv_top: W must be even and at least 4");
   end
   if (STEPS < 1 || (W % STEPS) != 0) begin : g_bad_steps
      $error("sdiv_top: STEPS must divide W");
   end

   // operand conditioning
   logic [DW-1:0] dd_w, dd_mag_w;
   logic [W-1:0]  dr_mag_w;
   logic          dd_neg_w, q_neg_w, dz_w, eovf_w;

   assign dd_w = odd_mode ? {dvd_lo, dvd_lo} : {dvd_hi, dvd_lo};

   sdiv_prep #(.W(W)) u_prep (
      .dd       (dd_w),
      .dr       (dvs),
      .dd_mag   (dd_mag_w),
      .dr_mag   (dr_mag_w),
      .dd_neg   (dd_neg_w),
      .q_neg    (q_neg_w),
      .dr_zero  (dz_w),
      .early_ovf(eovf_w)
   );

   // working state
   sdiv_state_e   st;
   logic [CW-1:0] cnt;
   logic [W-1:0]  rem_r, quo_r, dr_mag_r;
   logic          dd_neg_r, q_neg_r, dz_r, eovf_r, odd_r;

   // iteration chain, STEPS stages per clock
   logic [W-1:0] rem_c [STEPS+1];
   logic [W-1:0] quo_c [STEPS+1];

   assign rem_c[0] = rem_r;
   assign quo_c[0] = quo_r;

   for (genvar g = 0; g < STEPS; g++) begin : g_step
      sdiv_step #(.W(W)) u_step (
         .rem_i (rem_c[g]),
         .quo_i (quo_c[g]),
         .dr_mag(dr_mag_r),
         .rem_o (rem_c[g+1]),
         .quo_o (quo_c[g+1])
      );
   end

   // sign correction and flag forming
   logic [W-1:0] fin_q, fin_r;
   logic         late_ovf;
   sdiv_flags_t  fin_f;

   always_comb begin
      late_ovf = q_neg_r ? (quo_r > Q_NEG_LIM) : (quo_r > Q_POS_LIM);
      fin_q    = q_neg_r ? (W'(0) - quo_r) : quo_r;
      fin_r    = dd_neg_r ? (W'(0) - rem_r) : rem_r;
      if (dz_r) begin
         fin_f = '{n: 1'b0, z: 1'b1, v: 1'b1, c: 1'b1};
         fin_q = '0;
         fin_r = '0;
      end else if (eovf_r || late_ovf) begin
         fin_f = '{n: q_neg_r, z: 1'b0, v: 1'b1, c: 1'b0};
         fin_q = '0;
         fin_r = '0;
      end else begin
         fin_f = '{n: fin_q[W-1], z: (fin_q == '0), v: 1'b0, c: 1'b0};
      end
      if (odd_r) fin_q = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         cnt      <= '0;
         rem_r    <= '0;
         quo_r    <= '0;
         dr_mag_r <= '0;
         dd_neg_r <= 1'b0;
         q_neg_r  <= 1'b0;
         dz_r     <= 1'b0;
         eovf_r   <= 1'b0;
         odd_r    <= 1'b0;
         quot     <= '0;
         rem      <= '0;
         flags    <= '0;
         done     <= 1'b0;
      end else begin
         done <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (start) begin
                  rem_r    <= dd_mag_w[DW-1:W];
                  quo_r    <= dd_mag_w[W-1:0];
                  dr_mag_r <= dr_mag_w;
                  dd_neg_r <= dd_neg_w;
                  q_neg_r  <= q_neg_w;
                  dz_r     <= dz_w;
                  eovf_r   <= eovf_w;
                  odd_r    <= odd_mode;
                  cnt      <= '0;
                  st       <= ST_RUN;
               end
            end
            ST_RUN: begin
               rem_r <= rem_c[STEPS];
               quo_r <= quo_c[STEPS];
               cnt   <= cnt + 1'b1;
               if (cnt == CW'(NITER - 1)) st <= ST_FIN;
            end
            ST_FIN: begin
               quot  <= fin_q;
               rem   <= fin_r;
               flags <= fin_f;
               done  <= 1'b1;
               st    <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   // checks placed beside the logic they guard
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R2
   AST_IGNORE_START: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_RUN) && start |=> $stable(dr_mag_r)); // R3
   AST_ZERO_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
      done && dz_r |-> flags == 4'b0111); // R4
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      done && !flags[1] && !odd_r |-> (flags[3] == quot[W-1]) && (flags[2] == (quot == '0)) && !flags[0]); // R5
   AST_REM_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
      done && !flags[1] && (rem != '0) |-> rem[W-1] == dd_neg_r); // R1
   AST_OVF_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      done && flags[1] && !dz_r |-> !flags[0] && !flags[2]); // R6
   AST_ODD_QUOT: assert property (@(posedge clk) disable iff (!rst_n)
      done && odd_r |-> quot == '0); // R9
endmodule

// File: tb/sdiv_top_bench.sv
module sdiv_top_bench;
   localparam int W   = 16;
   localparam int LAT = W + 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          odd_mode = 1'b0;
   logic [W-1:0]  dvd_hi = '0, dvd_lo = '0, dvs = '0;
   logic [W-1:0]  quot, rem;
   logic [3:0]    flags;
   logic          done;

   int total = 0;
   int bad   = 0;
   int cyc   = 0;
   bit finished = 1'b0;

   // reference model state
   int          m_cnt = 0;
   bit          m_done = 1'b0;
   logic [3:0]  m_flags;
   longint      m_q, m_r;
   bit          m_odd;
   string       m_tag;

   always #5 clk = ~clk;

   sdiv_top #(.W(W), .STEPS(1)) u_sdiv_top (
      .clk(clk), .rst_n(rst_n), .start(start), .odd_mode(odd_mode),
      .dvd_hi(dvd_hi), .dvd_lo(dvd_lo), .dvs(dvs),
      .quot(quot), .rem(rem), .flags(flags), .done(done)
   );

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // behavioural reference, acts on each rising edge
   always @(posedge clk) begin
      if (rst_n) begin
         longint dd, dr, q;
         m_done = 1'b0;
         if (m_cnt > 0) begin
            m_cnt--;
            if (m_cnt == 0) m_done = 1'b1;
         end else if (start) begin
            m_odd = odd_mode;
            dd = odd_mode ? longint'($signed({dvd_lo, dvd_lo})) : longint'($signed({dvd_hi, dvd_lo}));
            dr = longint'($signed(dvs));
            m_cnt = LAT;
            if (dr == 0) begin
               m_flags = 4'b0111; m_tag = "R4"; m_q = 0; m_r = 0;
            end else begin
               q = dd / dr;
               m_r = dd % dr;
               if (q > 32767 || q < -32768) begin
                  m_flags = {q < 0, 1'b0, 1'b1, 1'b0}; m_tag = "R6/R8"; m_q = 0;
               end else begin
                  m_flags = {q < 0, q == 0, 1'b0, 1'b0};
                  m_tag = (q == -32768) ? "R7" : "R1/R5";
                  m_q = odd_mode ? 0 : q;
               end
               if (odd_mode) m_tag = "R9";
            end
         end
      end
   end

   // comparison away from the active edge
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         check(done == m_done, "R2 done timing", done, m_done);
         if (m_done) begin
            check(flags == m_flags, {m_tag, " flags"}, flags, m_flags);
            if (!m_flags[1]) begin
               check($signed(quot) == m_q, {m_tag, " quotient"}, $signed(quot), m_q);
               check($signed(rem) == m_r, {m_tag, " remainder"}, $signed(rem), m_r);
            end
         end
      end
   end

   task automatic run(input logic [W-1:0] h, input logic [W-1:0] l, input logic [W-1:0] d, input bit odd);
      @(negedge clk);
      dvd_hi = h; dvd_lo = l; dvs = d; odd_mode = odd; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (LAT + 1) @(negedge clk);
   endtask

   task automatic run32(input longint dd, input longint d);
      logic [31:0] v;
      v = 32'(dd);
      run(v[31:16], v[15:0], 16'(d), 1'b0);
   endtask

   initial begin
      logic [31:0] seed;
      seed = 32'h1234_5678;
      repeat (3) @(negedge clk);
      // R10 reset state
      check(done == 1'b0, "R10 done", done, 0);
      check(quot == '0, "R10 quot", quot, 0);
      check(rem == '0, "R10 rem", rem, 0);
      check(flags == '0, "R10 flags", flags, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(done == 1'b0 && flags == '0, "R10 after release", done, 0);

      // R1 R5 quadrants and small values
      run32(0, 3); run32(4, 3); run32(-4, 3); run32(-1, 3);
      run32(3, -3); run32(-3, -3); run32(-2, -3);
      run32(34, 5); run32(34, -5); run32(-34, 5); run32(-34, -5);
      // R4 zero divisor
      run32(0, 0); run32(1, 0); run32(-1, 0);
      // R6 R8 overflow boundaries
      run32(-32767, -1); run32(-32768, -1); run32(-32769, -1);
      run32(-65534, -2); run32(-65535, -2); run32(-65536, -2);
      run32(64'h7fffffff, 1); run32(64'h7fffffff, -1); run32(64'h7fffffff, -2);
      run32(-64'sd2147483648, 1); run32(-64'sd2147483648, -1);
      run32(1073709056, 32767); run32(1073709055, 32767);
      run32(-1073741823, 32767); run32(-1073741824, -32768);
      // R7 most negative quotient is legal
      run32(715871573, -21846); run32(715871574, -21846);
      run32(-715871573, 21846); run32(-715871574, 21846);
      run32(1073774591, -32768); run32(1073741824, -32768);
      // R9 single-register form, upper word is don't-care
      run(16'hbeef, 16'd7, 16'd16, 1'b1);
      run(16'h1234, 16'd7, 16'd17, 1'b1);
      run(16'h0, 16'd7, 16'd19, 1'b1);
      run(16'hffff, 16'd0, 16'd1, 1'b1);
      run(16'h5555, 16'h8001, 16'd3, 1'b1);
      // R3 start while busy is ignored
      @(negedge clk);
      dvd_hi = 16'h0; dvd_lo = 16'd100; dvs = 16'd7; odd_mode = 1'b0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (4) @(negedge clk);
      dvd_hi = 16'hffff; dvd_lo = 16'hff00; dvs = 16'd0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (LAT) @(negedge clk);
      // R1 R5 R6 mixed sweep
      for (int i = 0; i < 300; i++) begin
         logic [15:0] l, h, d;
         seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
         l = seed[15:0];
         d = seed[31:16];
         if (i % 3 == 0) d = {{8{d[15]}}, d[7:0]};
         h = {16{l[15]}} ^ {8'h00, seed[23:16] & 8'h3f};
         if (i % 4 == 0) h = seed[31:16];
         run(h, l, d, (i % 7) == 0);
      end
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   // watchdog
   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000 && !finished) begin
         finished = 1'b1;
         total++; bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule